// File: doc/BRIEF.md
# Extended Opcode Instruction Decoder

This block turns a 32-bit instruction word into a single operation code for the integer execution stage. It handles three primary opcodes. The first carries integer arithmetic, compare, barrier and condition-move instructions. The second carries conditional branches. The third carries a sign-extending word load. Under the arithmetic primary opcode, several instruction layouts share the same word. They place their extended opcode at different bit positions and with different widths. The decoder therefore checks the layouts in a fixed priority order, and the first one that matches decides the operation.

The decoder looks up three fields in order. First comes the ten-bit field. Next comes the nine-bit field used by the arithmetic group, in which the overflow-enable bit is left out of the lookup. Last comes the ten-bit condition-move field. When nothing matches, the decoder raises an unknown flag and reports the no-operation code. All results are registered: a word presented with `in_valid` high shows up on the outputs one clock later, together with `out_valid`. Bit numbers below use the little-endian convention, where bit 31 is the most significant bit.

Top module: `ext_opcode_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `op_q`, `oe_q`, `unknown_q` and `disp_q` are all cleared to zero.
- R2: `out_valid` equals the value `in_valid` had one clock earlier. When `in_valid` is low, `op_q`, `oe_q`, `unknown_q` and `disp_q` keep their values.
- R3: The primary opcode is `in_insn[31:26]`. Any value other than 19, 31 or 58 gives `unknown_q`=1 and `op_q`=0.
- R4: With primary opcode 31, the ten-bit field `in_insn[10:1]` decodes as follows: 0 gives op 17, 183 gives op 18, 339 gives op 19, 598 gives op 20 and 854 gives op 21.
- R5: With primary opcode 31 and no ten-bit hit, the nine-bit field `in_insn[9:1]` decodes as follows, and bit 10 does not change the operation: 266→1, 40→2, 10→3, 8→4, 104→5, 138→6, 234→7, 136→8, 232→9, 202→10, 200→11, 75→12, 11→13, 235→14, 491→15, 459→16.
- R6: `oe_q` equals `in_insn[10]` when the nine-bit field decided the operation, and is 0 otherwise.
- R7: The ten-bit field is checked first, then the nine-bit field, and only after both have failed is the ten-bit condition-move lookup tried: 144 gives op 22 and 19 gives op 23. Any other value is unknown.
- R8: With primary opcode 58, a low field `in_insn[1:0]` equal to 2 gives op 24, and `disp_q` = {`in_insn[15:2]`, 2'b00}. Other values of the low field are unknown. `disp_q` is 0 for every other result.
- R9: With primary opcode 19, the ten-bit field `in_insn[10:1]` decodes as follows: 16 gives op 25 and 528 gives op 26. Any other value is unknown.
- R10: An instruction that matches nothing gives `unknown_q`=1, `op_q`=0 and `oe_q`=0. A decoded instruction gives `unknown_q`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word present this cycle |
| in_insn | input | 32 | Instruction word |
| out_valid | output | 1 | Registered result valid |
| op_q | output | 5 | Operation code, where 0 means no operation |
| oe_q | output | 1 | Overflow-enable bit of an arithmetic-group instruction |
| unknown_q | output | 1 | No lookup matched the instruction |
| disp_q | output | 16 | Word-aligned displacement of the signed word load |

## Verification
The assertions assume that `rst` is held high from time zero until the first clock edge has passed. They also assume that `in_valid` and `in_insn` settle well clear of the rising edge, because the hold and priority properties compare registered outputs with input values one cycle back. The bench meets both assumptions by changing inputs only on the falling edge and reading outputs on the next falling edge. It keeps reset high for several cycles before releasing it. Every instruction word it sends has known fields, so each result can be predicted from the tables in the requirements.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;
  localparam int INSN_W   = 32;
  localparam int OP_W     = 5;
  localparam int PRI_W    = 6;
  localparam int WIDE_W   = 10;
  localparam int NARROW_W = WIDE_W - 1;
  localparam int LOW_W    = 2;
  localparam int DISP_W   = 16;
  localparam int PRI_LSB  = INSN_W - PRI_W;
  localparam int FLD_LSB  = 1;
  localparam int OE_POS   = FLD_LSB + NARROW_W;

  localparam logic [PRI_W-1:0] PRI_BRANCH = PRI_W'(19);
  localparam logic [PRI_W-1:0] PRI_ALU    = PRI_W'(31);
  localparam logic [PRI_W-1:0] PRI_LOADW  = PRI_W'(58);
  localparam logic [LOW_W-1:0] LOW_LOAD_SX = LOW_W'(2);

  typedef enum logic [OP_W-1:0] {
    OP_NOP          = 5'd0,
    OP_ADD          = 5'd1,
    OP_SUB_FROM     = 5'd2,
    OP_ADD_CY       = 5'd3,
    OP_SUB_FROM_CY  = 5'd4,
    OP_NEGATE       = 5'd5,
    OP_ADD_EX       = 5'd6,
    OP_ADD_M1_EX    = 5'd7,
    OP_SUB_FROM_EX  = 5'd8,
    OP_SUB_M1_EX    = 5'd9,
    OP_ADD_Z_EX     = 5'd10,
    OP_SUB_Z_EX     = 5'd11,
    OP_MUL_HI_S     = 5'd12,
    OP_MUL_HI_U     = 5'd13,
    OP_MUL_LO       = 5'd14,
    OP_DIV_S        = 5'd15,
    OP_DIV_U        = 5'd16,
    OP_COMPARE      = 5'd17,
    OP_STORE_IX_UPD = 5'd18,
    OP_READ_SPECIAL = 5'd19,
    OP_MEM_FENCE    = 5'd20,
    OP_IO_FENCE     = 5'd21,
    OP_COND_WRITE   = 5'd22,
    OP_COND_READ    = 5'd23,
    OP_LOAD_WORD_SX = 5'd24,
    OP_BRANCH_LINK  = 5'd25,
    OP_BRANCH_COUNT = 5'd26
  } op_e;
endpackage

// File: rtl/dec_wide_tbl.sv
module dec_wide_tbl
  import insn_dec_pkg::*;
(
  input  logic [WIDE_W-1:0] code,
  input  logic              sel_alu,
  input  logic              sel_branch,
  output logic              hit,
  output op_e               op
);
  always_comb begin
    op = OP_NOP;
    if (sel_alu) begin
      case (code)
        WIDE_W'(0):   op = OP_COMPARE;
        WIDE_W'(183): op = OP_STORE_IX_UPD;
        WIDE_W'(339): op = OP_READ_SPECIAL;
        WIDE_W'(598): op = OP_MEM_FENCE;
        WIDE_W'(854): op = OP_IO_FENCE;
        default:      op = OP_NOP;
      endcase
    end else if (sel_branch) begin
      case (code)
        WIDE_W'(16):  op = OP_BRANCH_LINK;
        WIDE_W'(528): op = OP_BRANCH_COUNT;
        default:      op = OP_NOP;
      endcase
    end
    hit = (op != OP_NOP);
  end
endmodule

// File: rtl/dec_narrow_tbl.sv
module dec_narrow_tbl
  import insn_dec_pkg::*;
(
  input  logic [NARROW_W-1:0] code,
  input  logic                sel,
  output logic                hit,
  output op_e                 op
);
  always_comb begin
    op = OP_NOP;
    if (sel) begin
      case (code)
        NARROW_W'(266): op = OP_ADD;
        NARROW_W'(40):  op = OP_SUB_FROM;
        NARROW_W'(10):  op = OP_ADD_CY;
        NARROW_W'(8):   op = OP_SUB_FROM_CY;
        NARROW_W'(104): op = OP_NEGATE;
        NARROW_W'(138): op = OP_ADD_EX;
        NARROW_W'(234): op = OP_ADD_M1_EX;
        NARROW_W'(136): op = OP_SUB_FROM_EX;
        NARROW_W'(232): op = OP_SUB_M1_EX;
        NARROW_W'(202): op = OP_ADD_Z_EX;
        NARROW_W'(200): op = OP_SUB_Z_EX;
        NARROW_W'(75):  op = OP_MUL_HI_S;
        NARROW_W'(11):  op = OP_MUL_HI_U;
        NARROW_W'(235): op = OP_MUL_LO;
        NARROW_W'(491): op = OP_DIV_S;
        NARROW_W'(459): op = OP_DIV_U;
        default:        op = OP_NOP;
      endcase
    end
    hit = (op != OP_NOP);
  end
endmodule

// File: rtl/dec_late_tbl.sv
module dec_late_tbl
  import insn_dec_pkg::*;
(
  input  logic [WIDE_W-1:0] code,
  input  logic              sel,
  output logic              hit,
  output op_e               op
);
  always_comb begin
    op = OP_NOP;
    if (sel) begin
      case (code)
        WIDE_W'(144): op = OP_COND_WRITE;
        WIDE_W'(19):  op = OP_COND_READ;
        default:      op = OP_NOP;
      endcase
    end
    hit = (op != OP_NOP);
  end
endmodule

// File: rtl/ext_opcode_decoder.sv
module ext_opcode_decoder
  import insn_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       in_insn,
  output logic              out_valid,
  output logic [4:0]        op_q,
  output logic              oe_q,
  output logic              unknown_q,
  output logic [15:0]       disp_q
);
  logic [PRI_W-1:0]    pri;
  logic [WIDE_W-1:0]   wide_fld;
  logic [NARROW_W-1:0] narrow_fld;
  logic [LOW_W-1:0]    low_fld;
  logic                oe_bit;
  logic                is_alu, is_branch, is_loadw;
  logic                wide_hit, narrow_hit, late_hit, load_hit;
  op_e                 wide_op, narrow_op, late_op;
  op_e                 op_d;
  logic                oe_d, unk_d;
  logic [DISP_W-1:0]   disp_d;
  logic                unused_bits;

  assign pri        = in_insn[INSN_W-1:PRI_LSB];
  assign wide_fld   = in_insn[FLD_LSB+WIDE_W-1:FLD_LSB];
  assign narrow_fld = in_insn[FLD_LSB+NARROW_W-1:FLD_LSB];
  assign oe_bit     = in_insn[OE_POS];
  assign low_fld    = in_insn[LOW_W-1:0];
  assign is_alu     = (pri == PRI_ALU);
  assign is_branch  = (pri == PRI_BRANCH);
  assign is_loadw   = (pri == PRI_LOADW);
  assign load_hit   = is_loadw && (low_fld == LOW_LOAD_SX);
  assign unused_bits = ^in_insn[PRI_LSB-1:DISP_W];

  dec_wide_tbl u_wide (
    .code(wide_fld), .sel_alu(is_alu), .sel_branch(is_branch),
    .hit(wide_hit), .op(wide_op)
  );

  dec_narrow_tbl u_narrow (
    .code(narrow_fld), .sel(is_alu), .hit(narrow_hit), .op(narrow_op)
  );

  dec_late_tbl u_late (
    .code(wide_fld), .sel(is_alu), .hit(late_hit), .op(late_op)
  );

  always_comb begin
    op_d   = OP_NOP;
    oe_d   = 1'b0;
    unk_d  = 1'b0;
    disp_d = '0;
    if (wide_hit) begin
      op_d = wide_op;
    end else if (narrow_hit) begin
      op_d = narrow_op;
      oe_d = oe_bit;
    end else if (late_hit) begin
      op_d = late_op;
    end else if (load_hit) begin
      op_d   = OP_LOAD_WORD_SX;
      disp_d = {in_insn[DISP_W-1:LOW_W], {LOW_W{1'b0}}};
    end else begin
      unk_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      op_q      <= '0;
      oe_q      <= 1'b0;
      unknown_q <= 1'b0;
      disp_q    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        op_q      <= op_d;
        oe_q      <= oe_d;
        unknown_q <= unk_d;
        disp_q    <= disp_d;
      end
    end
  end

  // R2
  valid_lag_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_valid == $past(in_valid)));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(op_q) && $stable(oe_q) && $stable(unknown_q) && $stable(disp_q)));

  // R7
  wide_first_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && wide_hit) |=> ((op_q == $past(wide_op)) && !oe_q));

  // R6
  oe_from_narrow_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !wide_hit && narrow_hit) |=> (oe_q == $past(oe_bit)));

  // R8
  disp_align_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && op_q == OP_LOAD_WORD_SX) |-> (disp_q[LOW_W-1:0] == '0));

  // R10
  unknown_nop_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && unknown_q) |-> ((op_q == '0) && !oe_q && (disp_q == '0)));
endmodule

// File: tb/ext_opcode_decoder_tb.sv
`timescale 1ns/1ps
module ext_opcode_decoder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_insn = '0;
  logic        out_valid, oe_q, unknown_q;
  logic [4:0]  op_q;
  logic [15:0] disp_q;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ext_opcode_decoder u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn),
    .out_valid(out_valid), .op_q(op_q), .oe_q(oe_q),
    .unknown_q(unknown_q), .disp_q(disp_q)
  );

  task automatic expect_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] word(logic [5:0] pri, logic [9:0] fld, logic rc);
    return {pri, 15'h2B5A, fld, rc};
  endfunction

  task automatic send(logic [31:0] w);
    @(negedge clk);
    in_insn  = w;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_result(string req, logic [4:0] op, logic oe, logic unk, logic [15:0] disp);
    expect_eq(req, "out_valid", 32'(out_valid), 32'd1);
    expect_eq(req, "op", 32'(op_q), 32'(op));
    expect_eq(req, "oe", 32'(oe_q), 32'(oe));
    expect_eq(req, "unknown", 32'(unknown_q), 32'(unk));
    expect_eq(req, "disp", 32'(disp_q), 32'(disp));
  endtask

  task automatic t_reset();
    in_insn  = word(6'd31, 10'd266, 1'b0);
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs cleared while reset is held even with a valid word present
    expect_eq("R1", "out_valid", 32'(out_valid), 0);
    expect_eq("R1", "op", 32'(op_q), 0);
    expect_eq("R1", "oe", 32'(oe_q), 0);
    expect_eq("R1", "unknown", 32'(unknown_q), 0);
    expect_eq("R1", "disp", 32'(disp_q), 0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_foreign_primary();
    logic [5:0] pris [4] = '{6'd0, 6'd18, 6'd30, 6'd63};
    foreach (pris[i]) begin
      send(word(pris[i], 10'd266, 1'b0));
      expect_result("R3", 5'd0, 1'b0, 1'b1, 16'd0);
    end
  endtask

  task automatic t_wide();
    int codes [5] = '{0, 183, 339, 598, 854};
    int ops   [5] = '{17, 18, 19, 20, 21};
    foreach (codes[i]) begin
      send(word(6'd31, 10'(codes[i]), 1'(i % 2)));
      // R4 decode; code 598 also has narrow value 86, wide wins per R7
      expect_result("R4", 5'(ops[i]), 1'b0, 1'b0, 16'd0);
    end
  endtask

  task automatic t_narrow();
    int codes [16] = '{266, 40, 10, 8, 104, 138, 234, 136, 232, 202, 200, 75, 11, 235, 491, 459};
    for (int i = 0; i < 16; i++) begin
      for (int oe = 0; oe < 2; oe++) begin
        send(word(6'd31, {1'(oe), 9'(codes[i])}, 1'b0));
        // R5 same op for both values of bit 10; R6 oe reported
        expect_eq("R5", "op", 32'(op_q), 32'(i + 1));
        expect_eq("R6", "oe", 32'(oe_q), 32'(oe));
        expect_eq("R10", "unknown", 32'(unknown_q), 0);
      end
    end
  endtask

  task automatic t_late();
    send(word(6'd31, 10'd144, 1'b0));
    expect_result("R7", 5'd22, 1'b0, 1'b0, 16'd0);
    send(word(6'd31, 10'd19, 1'b1));
    expect_result("R7", 5'd23, 1'b0, 1'b0, 16'd0);
    // R7: bit 10 set makes the ten-bit value 656, no lookup matches
    send(word(6'd31, 10'd656, 1'b0));
    expect_result("R7", 5'd0, 1'b0, 1'b1, 16'd0);
  endtask

  task automatic t_load();
    send({6'd58, 10'h155, 16'hABCE});
    expect_result("R8", 5'd24, 1'b0, 1'b0, 16'hABCC);
    for (int lo = 0; lo < 4; lo++) begin
      if (lo != 2) begin
        send({6'd58, 10'h155, 14'h2AF3, 2'(lo)});
        expect_result("R8", 5'd0, 1'b0, 1'b1, 16'd0);
      end
    end
  endtask

  task automatic t_branch();
    send(word(6'd19, 10'd16, 1'b0));
    expect_result("R9", 5'd25, 1'b0, 1'b0, 16'd0);
    send(word(6'd19, 10'd528, 1'b1));
    expect_result("R9", 5'd26, 1'b0, 1'b0, 16'd0);
    // R9: arithmetic codes are not decoded under the branch primary
    send(word(6'd19, 10'd266, 1'b0));
    expect_result("R9", 5'd0, 1'b0, 1'b1, 16'd0);
    send(word(6'd19, 10'd0, 1'b0));
    expect_result("R9", 5'd0, 1'b0, 1'b1, 16'd0);
  endtask

  task automatic t_unknown();
    send(word(6'd31, 10'd1, 1'b0));
    expect_result("R10", 5'd0, 1'b0, 1'b1, 16'd0);
    send(word(6'd31, 10'd1023, 1'b1));
    expect_result("R10", 5'd0, 1'b0, 1'b1, 16'd0);
  endtask

  task automatic t_hold();
    send(word(6'd31, 10'd747, 1'b0));
    expect_result("R2", 5'd14, 1'b1, 1'b0, 16'd0);
    @(negedge clk);
    in_insn = {6'd58, 10'h3FF, 16'hFFFE};
    repeat (3) @(negedge clk);
    // R2: idle cycles leave every result output unchanged
    expect_eq("R2", "out_valid idle", 32'(out_valid), 0);
    expect_eq("R2", "op held", 32'(op_q), 14);
    expect_eq("R2", "oe held", 32'(oe_q), 1);
    expect_eq("R2", "disp held", 32'(disp_q), 0);
  endtask

  initial begin
    t_reset();
    t_foreign_primary();
    t_wide();
    t_narrow();
    t_late();
    t_load();
    t_branch();
    t_unknown();
    t_hold();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule